// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital control and status logic that sits around an 8-bit analog-to-digital converter. A CPU-side bus writes a control word and reads a control/status word and a result word. The conversion timing runs in a separate converter clock domain. The analog front end is modelled by a digital sample input, `sample_in`. The block scales that input to an 8-bit code at the end of each conversion. The code is carried back to the bus domain, where it is loaded into the result register and a done flag is set.

Every write to the control word starts a new conversion. The request crosses into the converter domain through a toggle synchronizer, and a conversion already in progress is abandoned. A conversion takes exactly sixteen converter clocks. In single mode the sequencer then goes idle. In continuous mode it converts back to back and overwrites the result each time. Writing the all-ones channel code halts the sequencer. A level interrupt request follows the done flag when interrupts are enabled.

A result is tagged with the polarity of the request toggle that started its conversion. The bus side accepts a result only while that tag matches its own current toggle, so a result from an abandoned conversion never reaches the registers. Control writes must be at least four converter clocks apart.

Top module: `adcseq_top`

## Requirements
- R1: After reset, the control word (`bus_addr`=0) reads 0x1F: done flag bit 7 = 0, interrupt-enable bit 6 = 0, continuous bit 5 = 0, channel bits 4:0 = 0x1F (halt). The result word (`bus_addr`=1) reads 0x00, `irq` is 0 and `chan_sel` is 0x1F.
- R2: A conversion is busy for exactly 16 converter clocks. Seen from the bus, the done flag appears between 400 ns and 600 ns after a control write, with a 25 ns converter clock and a 10 ns bus clock.
- R3: The code is 0x00 when sample_in <= 100 and 0xFF when sample_in >= 868. Otherwise it is floor((sample_in-100)*255/768).
- R4: A control write with bit 5 = 0 and a channel other than 0x1F performs exactly one conversion. The code is loaded into the result word and the done flag is set, and no further done flag follows.
- R5: The done flag is cleared by any control write and by a read of the result word.
- R6: `irq` is high exactly while the done flag and interrupt-enable bit 6 are both set, and it falls when the flag is cleared.
- R7: With bit 5 = 1, conversions repeat back to back, and each new code overwrites the result word whether it was read or not.
- R8: Writing bit 5 = 0 during continuous operation lets one final conversion complete and then stops. Writing channel 0x1F stops at once with no further done flag.
- R9: A control write during a conversion abandons it and restarts. The result delivered is the sample taken at the end of the restarted conversion, no earlier than 16 converter clocks after the second write.
- R10: `chan_sel` equals control bits 4:0 from the last write, and control bits 6:0 read back as written.
- R11: The result word changes only in a cycle where the done flag is being set. A result from an abandoned conversion is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a result-word read clears the done flag) |
| bus_addr | input | 1 | 0 = control/status word, 1 = result word |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed word |
| irq | output | 1 | Level interrupt request |
| chan_sel | output | 5 | Selected channel for the input multiplexer |
| cnv_clk | input | 1 | Converter clock, asynchronous to bus_clk |
| cnv_rst_n | input | 1 | Converter-domain asynchronous reset, active low |
| sample_in | input | 10 | Digital stand-in for the analog input, taken at the end of each conversion |

## Verification
The bench sweeps the input range in steps and also hits every saturation edge (99 to 104, 867 to 869, 0, 1023). An off-by-one in the clamp or the scaling would show up as a wrong code at these points. It restarts a conversion halfway through. A design that let the abandoned result through would raise the flag too early or deliver the first sample's code. It stops continuous mode in both ways, by clearing the continuous bit and by selecting the halt channel. A sequencer that kept running, or dropped the final conversion, would leave a flag where none is expected or miss one that is. It also leaves continuous results unread, which catches a design that blocks overwrites or loses the flag when the result is read.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/100ps
package adcseq_pkg;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;
    // Control word bit positions counted down from the top of the data word
    localparam int unsigned OFS_FLAG = 1;
    localparam int unsigned OFS_IEN  = 2;
    localparam int unsigned OFS_CONT = 3;
endpackage

// File: rtl/adcseq_tsync.sv
`timescale 1ns/100ps
module adcseq_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic level,
    output logic pulse
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], tgl_in};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sh[STAGES-1];
    assign pulse = st_q.sh[STAGES-1] ^ st_q.prev;
endmodule

// File: rtl/adcseq_scale.sv
`timescale 1ns/100ps
module adcseq_scale #(
    parameter int IN_W   = 10,
    parameter int RES_W  = 8,
    parameter int REF_LO = 100,
    parameter int REF_HI = 868
) (
    input  logic [IN_W-1:0]  sample,
    output logic [RES_W-1:0] code
);
    localparam int PW = IN_W + RES_W + 1;
    localparam logic [PW-1:0] LO_P   = PW'(REF_LO);
    localparam logic [PW-1:0] HI_P   = PW'(REF_HI);
    localparam logic [PW-1:0] SPAN_P = PW'(REF_HI - REF_LO);
    localparam logic [PW-1:0] FULL_P = PW'((1 << RES_W) - 1);

    logic [PW-1:0] x_w, prod, quot;

    always_comb begin
        x_w  = PW'(sample);
        prod = (x_w - LO_P) * FULL_P;
        quot = prod / SPAN_P;
        if (x_w <= LO_P)      code = '0;
        else if (x_w >= HI_P) code = '1;
        else                  code = quot[RES_W-1:0];
    end
endmodule

// File: rtl/adcseq_core.sv
`timescale 1ns/100ps
module adcseq_core #(
    parameter int IN_W        = 10,
    parameter int RES_W       = 8,
    parameter int CONV_CYC    = 16,
    parameter int REF_LO      = 100,
    parameter int REF_HI      = 868,
    parameter int SYNC_STAGES = 2
) (
    input  logic             cnv_clk,
    input  logic             cnv_rst_n,
    input  logic             start_tgl,
    input  logic             cfg_cont,
    input  logic             cfg_run,
    input  logic [IN_W-1:0]  sample_in,
    output logic             done_tgl,
    output logic [RES_W-1:0] res_data,
    output logic             res_gen
);
    localparam int CNT_W = $clog2(CONV_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             cont;
        logic             gen;
        logic [RES_W-1:0] res;
        logic             res_gen;
        logic             dtgl;
    } core_t;

    core_t st_d, st_q;
    logic start_pulse, start_lvl;
    logic [RES_W-1:0] scaled;

    adcseq_tsync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(cnv_clk), .rst_n(cnv_rst_n), .tgl_in(start_tgl),
        .level(start_lvl), .pulse(start_pulse)
    );

    adcseq_scale #(.IN_W(IN_W), .RES_W(RES_W), .REF_LO(REF_LO), .REF_HI(REF_HI)) u_scale (
        .sample(sample_in), .code(scaled)
    );

    always_comb begin
        st_d = st_q;
        if (start_pulse) begin
            st_d.busy = cfg_run;
            st_d.cnt  = '0;
            st_d.cont = cfg_cont;
            st_d.gen  = start_lvl;
        end else if (st_q.busy) begin
            if (st_q.cnt == LAST) begin
                st_d.res     = scaled;
                st_d.res_gen = st_q.gen;
                st_d.dtgl    = ~st_q.dtgl;
                st_d.cnt     = '0;
                st_d.busy    = st_q.cont;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge cnv_clk or negedge cnv_rst_n) begin
        if (!cnv_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign done_tgl = st_q.dtgl;
    assign res_data = st_q.res;
    assign res_gen  = st_q.res_gen;
endmodule

// File: rtl/adcseq_regs.sv
`timescale 1ns/100ps
module adcseq_regs
    import adcseq_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int CH_W        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [RES_W-1:0] bus_wdata,
    output logic [RES_W-1:0] bus_rdata,
    output logic             irq,
    output logic [CH_W-1:0]  chan_sel,
    output logic             start_tgl,
    output logic             cfg_cont,
    output logic             cfg_run,
    input  logic             done_tgl,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_gen
);
    localparam int B_FLAG = RES_W - OFS_FLAG;
    localparam int B_IEN  = RES_W - OFS_IEN;
    localparam int B_CONT = RES_W - OFS_CONT;

    typedef struct packed {
        logic             ien;
        logic             cont;
        logic [CH_W-1:0]  chan;
        logic             done;
        logic [RES_W-1:0] data;
        logic             tgl;
    } regs_t;

    regs_t st_d, st_q;
    logic ctrl_wr, data_rd, done_pulse, done_lvl, accept;
    logic [RES_W-1:0] ctrl_word;
    logic unused_inputs;

    adcseq_tsync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .tgl_in(done_tgl),
        .level(done_lvl), .pulse(done_pulse)
    );

    assign unused_inputs = bus_wdata[B_FLAG] ^ done_lvl;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign data_rd = bus_rd && (bus_addr == ADDR_DATA);
    assign accept  = done_pulse && !ctrl_wr && (res_gen == st_q.tgl);

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ien  = bus_wdata[B_IEN];
            st_d.cont = bus_wdata[B_CONT];
            st_d.chan = bus_wdata[CH_W-1:0];
            st_d.done = 1'b0;
            st_d.tgl  = ~st_q.tgl;
        end else if (accept) begin
            st_d.done = 1'b1;
            st_d.data = res_data;
        end else if (data_rd) begin
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            st_q      <= '0;
            st_q.chan <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_word             = '0;
        ctrl_word[B_FLAG]     = st_q.done;
        ctrl_word[B_IEN]      = st_q.ien;
        ctrl_word[B_CONT]     = st_q.cont;
        ctrl_word[CH_W-1:0]   = st_q.chan;
        bus_rdata = (bus_addr == ADDR_DATA) ? st_q.data : ctrl_word;
    end

    assign irq       = st_q.done && st_q.ien;
    assign chan_sel  = st_q.chan;
    assign start_tgl = st_q.tgl;
    assign cfg_cont  = st_q.cont;
    assign cfg_run   = (st_q.chan != '1);
endmodule

// File: rtl/adcseq_top.sv
`timescale 1ns/100ps
module adcseq_top #(
    parameter int IN_W        = 10,
    parameter int RES_W       = 8,
    parameter int CH_W        = 5,
    parameter int CONV_CYC    = 16,
    parameter int REF_LO      = 100,
    parameter int REF_HI      = 868,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [RES_W-1:0] bus_wdata,
    output logic [RES_W-1:0] bus_rdata,
    output logic             irq,
    output logic [CH_W-1:0]  chan_sel,
    input  logic             cnv_clk,
    input  logic             cnv_rst_n,
    input  logic [IN_W-1:0]  sample_in
);
    logic             start_tgl, cfg_cont, cfg_run;
    logic             done_tgl, res_gen;
    logic [RES_W-1:0] res_data;

    adcseq_regs #(.RES_W(RES_W), .CH_W(CH_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .chan_sel(chan_sel), .start_tgl(start_tgl),
        .cfg_cont(cfg_cont), .cfg_run(cfg_run), .done_tgl(done_tgl),
        .res_data(res_data), .res_gen(res_gen)
    );

    adcseq_core #(.IN_W(IN_W), .RES_W(RES_W), .CONV_CYC(CONV_CYC), .REF_LO(REF_LO),
                  .REF_HI(REF_HI), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .cnv_clk(cnv_clk), .cnv_rst_n(cnv_rst_n), .start_tgl(start_tgl),
        .cfg_cont(cfg_cont), .cfg_run(cfg_run), .sample_in(sample_in),
        .done_tgl(done_tgl), .res_data(res_data), .res_gen(res_gen)
    );
endmodule

// File: rtl/adcseq_chk.sv
`timescale 1ns/100ps
module adcseq_cnv_chk #(
    parameter int CONV_CYC = 16,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_pulse,
    input logic             cfg_run,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic             done_tgl
);
    logic [7:0] run_len;
    logic       tgl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len  <= '0;
            tgl_prev <= 1'b0;
        end else begin
            tgl_prev <= done_tgl;
            if (start_pulse)              run_len <= '0;
            else if (done_tgl != tgl_prev) run_len <= busy ? 8'd1 : 8'd0;
            else if (busy)                run_len <= run_len + 8'd1;
        end
    end

    assert_conv_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_tgl != tgl_prev) |-> (run_len == 8'(CONV_CYC)));

    assert_halt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !cfg_run) |=> !busy);

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && cfg_run) |=> (busy && cnt == '0));
endmodule

module adcseq_bus_chk #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             data_rd,
    input logic             done_pulse,
    input logic             done,
    input logic [RES_W-1:0] data,
    input logic             irq
);
    logic [RES_W-1:0] data_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_prev <= '0;
        else        data_prev <= data;
    end

    assert_wr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (!done && !irq));

    assert_rd_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !done_pulse) |=> !done);

    assert_irq_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> !irq);

    assert_data_with_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (data != data_prev) |-> done);
endmodule

bind adcseq_core adcseq_cnv_chk #(.CONV_CYC(CONV_CYC), .CNT_W(CNT_W)) u_cnv_chk (
    .clk(cnv_clk), .rst_n(cnv_rst_n), .start_pulse(start_pulse), .cfg_run(cfg_run),
    .busy(st_q.busy), .cnt(st_q.cnt), .done_tgl(done_tgl)
);

bind adcseq_regs adcseq_bus_chk #(.RES_W(RES_W)) u_bus_chk (
    .clk(bus_clk), .rst_n(bus_rst_n), .ctrl_wr(ctrl_wr), .data_rd(data_rd),
    .done_pulse(done_pulse), .done(st_q.done), .data(st_q.data), .irq(irq)
);

// File: tb/test_adcseq_top.sv
`timescale 1ns/100ps
module test_adcseq_top;
    logic       bus_clk, bus_rst_n, bus_wr, bus_rd, bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       irq;
    logic [4:0] chan_sel;
    logic       cnv_clk, cnv_rst_n;
    logic [9:0] sample_in;

    int checks = 0;
    int errors = 0;

    adcseq_top i_adcseq_top (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .chan_sel(chan_sel), .cnv_clk(cnv_clk), .cnv_rst_n(cnv_rst_n),
        .sample_in(sample_in)
    );

    initial begin
        bus_clk = 1'b0;
        forever #5 bus_clk = ~bus_clk;
    end

    initial begin
        cnv_clk = 1'b0;
        #3;
        forever begin
            cnv_clk = 1'b1; #12.5;
            cnv_clk = 1'b0; #12.5;
        end
    end

    function automatic int expect_code(input int v);
        if (v <= 100) return 0;
        if (v >= 868) return 255;
        return ((v - 100) * 255) / 768;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge bus_clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge bus_clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        logic [7:0] v;
        got = 1'b0;
        for (int k = 0; k < 150 && !got; k++) begin
            rd(1'b0, v);
            if (v[7]) got = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    initial begin
        repeat (200000) @(posedge bus_clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit got;
        realtime t0, dt;
        int pts[$];

        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; sample_in = 0;
        bus_rst_n = 0; cnv_rst_n = 0;
        idle(5);
        bus_rst_n = 1; cnv_rst_n = 1;
        idle(3);

        // R1 reset state
        rd(1'b0, v); chk(v == 8'h1F, "R1 ctrl reset", v, 8'h1F);
        rd(1'b1, v); chk(v == 8'h00, "R1 data reset", v, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        chk(chan_sel == 5'h1F, "R1 chan reset", chan_sel, 5'h1F);

        // Sweep with saturation edges: R2 R3 R4 R5 R6 R10
        pts = {0, 99, 100, 101, 102, 103, 104, 867, 868, 869, 1023};
        for (int x = 0; x < 1024; x += 9) pts.push_back(x);
        foreach (pts[i]) begin
            logic [7:0] cw;
            logic [4:0] ch;
            ch = 5'(i % 31);
            cw = {1'b0, (i % 2 == 0), 1'b0, ch};
            @(negedge bus_clk); sample_in = 10'(pts[i]);
            wr_ctrl(cw);
            t0 = $realtime;
            chk(chan_sel == ch, "R10 chan_sel", chan_sel, ch);
            wait_done(got);
            dt = $realtime - t0;
            chk(got, "R4 done set", got, 1);
            chk(dt >= 400.0 && dt <= 600.0, "R2 latency ns", int'(dt), 500);
            chk(irq == cw[6], "R6 irq with flag", irq, cw[6]);
            rd(1'b0, v); chk(v[6:0] == cw[6:0], "R10 readback", v[6:0], cw[6:0]);
            rd(1'b1, v); chk(v == 8'(expect_code(pts[i])), "R3 code", v, expect_code(pts[i]));
            rd(1'b0, v); chk(v[7] == 1'b0, "R5 read clears flag", v[7], 0);
            chk(irq == 1'b0, "R6 irq falls", irq, 0);
        end

        // R4 single mode performs only one conversion
        idle(120);
        rd(1'b0, v); chk(v[7] == 1'b0, "R4 no second done", v[7], 0);

        // R5 control write clears flag; R8 halt channel
        @(negedge bus_clk); sample_in = 10'd500;
        wr_ctrl(8'h43);
        wait_done(got);
        chk(irq == 1'b1, "R6 irq set", irq, 1);
        wr_ctrl(8'h5F);
        rd(1'b0, v); chk(v[7] == 1'b0, "R5 write clears flag", v[7], 0);
        chk(irq == 1'b0, "R5 write drops irq", irq, 0);
        idle(120);
        rd(1'b0, v); chk(v[7] == 1'b0, "R8 halt no done", v[7], 0);

        // R7 continuous overwrite without reading
        @(negedge bus_clk); sample_in = 10'd300;
        wr_ctrl(8'h61);
        wait_done(got);
        chk(got, "R7 first done", got, 1);
        rd(1'b1, v); chk(v == 8'(expect_code(300)), "R7 first code", v, expect_code(300));
        @(negedge bus_clk); sample_in = 10'd700;
        idle(120);
        rd(1'b0, v); chk(v[7] == 1'b1, "R7 flag set again", v[7], 1);
        rd(1'b1, v); chk(v == 8'(expect_code(700)), "R7 overwrite", v, expect_code(700));
        wait_done(got);
        chk(got, "R7 keeps running", got, 1);

        // R8 clearing continuous bit: one final conversion then idle
        @(negedge bus_clk); sample_in = 10'd868;
        wr_ctrl(8'h41);
        wait_done(got);
        chk(got, "R8 final conversion", got, 1);
        rd(1'b1, v); chk(v == 8'hFF, "R8 final code", v, 8'hFF);
        idle(120);
        rd(1'b0, v); chk(v[7] == 1'b0, "R8 stopped", v[7], 0);

        // R8 halt channel during continuous
        wr_ctrl(8'h62);
        wait_done(got);
        wr_ctrl(8'h7F);
        idle(120);
        rd(1'b0, v); chk(v[7] == 1'b0, "R8 halt in continuous", v[7], 0);

        // R9 R11 abort and restart: stale result discarded
        @(negedge bus_clk); sample_in = 10'd200;
        wr_ctrl(8'h44);
        idle(22);
        @(negedge bus_clk); sample_in = 10'd640;
        wr_ctrl(8'h44);
        t0 = $realtime;
        wait_done(got);
        dt = $realtime - t0;
        chk(dt >= 400.0, "R9 restart latency ns", int'(dt), 400);
        rd(1'b1, v); chk(v == 8'(expect_code(640)), "R11 restarted code", v, expect_code(640));
        idle(120);
        rd(1'b0, v); chk(v[7] == 1'b0, "R11 no stale done", v[7], 0);
        rd(1'b1, v); chk(v == 8'(expect_code(640)), "R11 data stable", v, expect_code(640));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule